// File: doc/BRIEF.md
# Shift and Immediate Arithmetic Unit

This block is the execution slice of a compact 16-bit instruction pipeline that handles three kinds of operation. The first kind shifts a source register by a constant amount. The second adds or subtracts either a second register or a small 3-bit constant. The third moves, compares, adds or subtracts using a constant of up to 8 bits. The decoded operation code, two 32-bit operands, the raw constant field and the incoming carry are presented every cycle. The block returns a registered result, a write strobe for the register file and the four condition flags, one clock after the inputs.

A single adder serves every add, subtract and compare. A single shifter serves the three shift kinds. The compare form produces flags only: the write strobe stays low and the result output keeps its previous value. Codes outside the defined set leave every output except the strobe untouched, so a pipeline bubble can be fed in as an unused code.

Top module: `sia_unit`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the following edge state is `res_out` = 0, `res_wr` = 0 and all four flags = 0.
- R2: Every output reflects the inputs sampled at the previous rising edge (one cycle of latency).
- R3: Code 0 shifts `opnd_a` left by `imm_fld[4:0]`. For an amount of 1 to 31, C is the last bit shifted out. For an amount of 0, the result is `opnd_a` and C equals `carry_in`.
- R4: Code 1 is a logical right shift and code 2 is an arithmetic right shift of `opnd_a` by `imm_fld[4:0]`. For an amount of 1 to 31, C is the last bit shifted out. An amount of 0 means a shift by 32: the result is all zeros (code 1) or 32 copies of bit 31 (code 2), and C equals bit 31.
- R5: Shifts read only `imm_fld[4:0]`. Codes 5 and 6 use `imm_fld[2:0]` zero-extended. Codes 7 to 10 use all of `imm_fld[7:0]` zero-extended. Higher field bits have no effect.
- R6: Codes 3 (a + b), 5 (a + 3-bit constant) and 9 (a + 8-bit constant) write the sum. C is the unsigned carry out and V is two's complement overflow.
- R7: Codes 4 (a − b), 6 (a − 3-bit constant) and 10 (a − 8-bit constant) write the difference. C is 1 when no borrow occurs (a ≥ operand, unsigned) and V is signed overflow.
- R8: Code 8 compares `opnd_a` with the 8-bit constant. Flags are set as for a subtract, `res_wr` is 0 and `res_out` keeps its previous value.
- R9: For codes 0 to 10, N is bit 31 and Z is set exactly when the computed value is zero. For code 8 the computed value is the difference.
- R10: Code 7 writes the zero-extended 8-bit constant with C equal to `carry_in`. Codes 0, 1, 2 and 7 clear V.
- R11: Codes 11 to 15 drive `res_wr` to 0 and leave `res_out` and all flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| op_sel | input | 4 | Operation code (0 to 10 defined) |
| opnd_a | input | 32 | First source operand / shift source |
| opnd_b | input | 32 | Second source operand for register forms |
| imm_fld | input | 8 | Raw constant field |
| carry_in | input | 1 | Current carry flag |
| res_out | output | 32 | Registered result |
| res_wr | output | 1 | Result write strobe |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_c | output | 1 | Carry flag |
| flag_v | output | 1 | Overflow flag |

## Verification
Within one issue, flag production and result retention interact: a compare must refresh all four flags while the result register holds a value left by an earlier, different operation. The bench provokes this by issuing a writing operation with one set of operands and then, on the very next cycle, a compare whose difference gives other N, Z and C values. It judges the outcome by requiring the old result with the strobe low, next to flags that match only the new difference. The same pairing is repeated with unused codes, where neither the flags nor the result may move.

// File: rtl/sia_pkg.sv
// Package: shared operation codes and decode types for the shift and
// immediate arithmetic unit. Assumes a 4-bit operation code.
package sia_pkg;

    typedef enum logic [3:0] {
        OP_LSL_I5  = 4'd0,
        OP_LSR_I5  = 4'd1,
        OP_ASR_I5  = 4'd2,
        OP_ADD_R   = 4'd3,
        OP_SUB_R   = 4'd4,
        OP_ADD_I3  = 4'd5,
        OP_SUB_I3  = 4'd6,
        OP_MOV_I8  = 4'd7,
        OP_CMP_I8  = 4'd8,
        OP_ADD_I8  = 4'd9,
        OP_SUB_I8  = 4'd10
    } op_e;

    typedef enum logic [1:0] {
        SH_LEFT  = 2'd0,
        SH_RIGHT = 2'd1,
        SH_ARITH = 2'd2
    } shift_e;

    typedef enum logic [1:0] {
        SRC_REG  = 2'd0,
        SRC_IMM3 = 2'd1,
        SRC_IMM8 = 2'd2
    } src_e;

    typedef struct packed {
        logic   known;
        logic   writes;
        logic   use_shift;
        logic   is_mov;
        logic   is_sub;
        shift_e kind;
        src_e   src;
    } ctrl_t;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } flags_t;

endpackage

// File: rtl/sia_decode.sv
// Module: sia_decode
// Turns the operation code into control fields and builds the second
// operand from the register or one of the two constant widths.
// Assumes IMM_W >= SMALL_W and DATA_W > IMM_W.
module sia_decode
    import sia_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int IMM_W   = 8,
    parameter int SMALL_W = 3
) (
    input  logic [3:0]        op_sel,
    input  logic [DATA_W-1:0] opnd_b,
    input  logic [IMM_W-1:0]  imm_fld,
    output ctrl_t             ctrl,
    output logic [DATA_W-1:0] opnd2
);

    localparam int PAD_SMALL = DATA_W - SMALL_W;
    localparam int PAD_WIDE  = DATA_W - IMM_W;

    // Map each code to its control fields; unknown codes mark known = 0.
    always_comb begin
        ctrl = '{known: 1'b1, writes: 1'b1, use_shift: 1'b0, is_mov: 1'b0,
                 is_sub: 1'b0, kind: SH_LEFT, src: SRC_REG};
        case (op_sel)
            OP_LSL_I5: begin ctrl.use_shift = 1'b1; ctrl.kind = SH_LEFT;  end
            OP_LSR_I5: begin ctrl.use_shift = 1'b1; ctrl.kind = SH_RIGHT; end
            OP_ASR_I5: begin ctrl.use_shift = 1'b1; ctrl.kind = SH_ARITH; end
            OP_ADD_R:  ctrl.src = SRC_REG;
            OP_SUB_R:  ctrl.is_sub = 1'b1;
            OP_ADD_I3: ctrl.src = SRC_IMM3;
            OP_SUB_I3: begin ctrl.src = SRC_IMM3; ctrl.is_sub = 1'b1; end
            OP_MOV_I8: begin ctrl.src = SRC_IMM8; ctrl.is_mov = 1'b1; end
            OP_CMP_I8: begin
                ctrl.src    = SRC_IMM8;
                ctrl.is_sub = 1'b1;
                ctrl.writes = 1'b0;
            end
            OP_ADD_I8: ctrl.src = SRC_IMM8;
            OP_SUB_I8: begin ctrl.src = SRC_IMM8; ctrl.is_sub = 1'b1; end
            default: begin
                ctrl.known  = 1'b0;
                ctrl.writes = 1'b0;
            end
        endcase
    end

    // Select the second operand and zero-extend the constant forms.
    always_comb begin
        case (ctrl.src)
            SRC_IMM3: opnd2 = {{PAD_SMALL{1'b0}}, imm_fld[SMALL_W-1:0]};
            SRC_IMM8: opnd2 = {{PAD_WIDE{1'b0}}, imm_fld};
            default:  opnd2 = opnd_b;
        endcase
    end

endmodule

// File: rtl/sia_shifter.sv
// Module: sia_shifter
// Constant-amount shifter for left, logical right and arithmetic right.
// For right shifts an amount of zero is read as a full-width shift; for
// left shifts it passes the operand and the incoming carry.
// Assumes DATA_W is a power of two.
module sia_shifter
    import sia_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int SHAMT_W = $clog2(DATA_W)
) (
    input  logic [DATA_W-1:0]  src,
    input  logic [SHAMT_W-1:0] amt,
    input  shift_e             kind,
    input  logic               cin,
    output logic [DATA_W-1:0]  res,
    output logic               cout
);

    localparam int MSB = DATA_W - 1;

    logic [SHAMT_W-1:0] idx_left;
    logic [SHAMT_W-1:0] idx_right;
    logic               amt_zero;

    // Position of the last bit leaving each end for a non-zero amount.
    always_comb begin
        idx_left  = SHAMT_W'(0) - amt;
        idx_right = amt - SHAMT_W'(1);
        amt_zero  = (amt == '0);
    end

    // Produce the shifted value and its carry for the selected kind.
    always_comb begin
        res  = src;
        cout = cin;
        case (kind)
            SH_RIGHT: begin
                if (amt_zero) begin
                    res  = '0;
                    cout = src[MSB];
                end else begin
                    res  = src >> amt;
                    cout = src[idx_right];
                end
            end
            SH_ARITH: begin
                if (amt_zero) begin
                    res  = {DATA_W{src[MSB]}};
                    cout = src[MSB];
                end else begin
                    res  = $signed(src) >>> amt;
                    cout = src[idx_right];
                end
            end
            default: begin
                if (!amt_zero) begin
                    res  = src << amt;
                    cout = src[idx_left];
                end
            end
        endcase
    end

endmodule

// File: rtl/sia_addsub.sv
// Module: sia_addsub
// One adder for add, subtract and compare. Subtract inverts the second
// operand and injects a carry of one, so carry out means no borrow.
module sia_addsub #(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic              sub,
    output logic [DATA_W-1:0] sum,
    output logic              cout,
    output logic              ovf
);

    localparam int MSB = DATA_W - 1;

    logic [DATA_W-1:0] b_eff;
    logic [DATA_W:0]   wide;

    // Add with optional inversion; overflow when like signs give unlike.
    always_comb begin
        b_eff = sub ? ~b : b;
        wide  = {1'b0, a} + {1'b0, b_eff} + {{DATA_W{1'b0}}, sub};
        sum   = wide[MSB:0];
        cout  = wide[DATA_W];
        ovf   = (a[MSB] == b_eff[MSB]) && (sum[MSB] != a[MSB]);
    end

endmodule

// File: rtl/sia_unit.sv
// Module: sia_unit (top)
// Registered execution unit for shifts by constant, register or constant
// add/subtract, move and compare. The outputs change one clock after the
// inputs. Unknown codes hold the result and flags and drop the strobe.
// Assumes a synchronous active-low reset.
module sia_unit
    import sia_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int IMM_W   = 8,
    parameter int SMALL_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [3:0]        op_sel,
    input  logic [DATA_W-1:0] opnd_a,
    input  logic [DATA_W-1:0] opnd_b,
    input  logic [IMM_W-1:0]  imm_fld,
    input  logic              carry_in,
    output logic [DATA_W-1:0] res_out,
    output logic              res_wr,
    output logic              flag_n,
    output logic              flag_z,
    output logic              flag_c,
    output logic              flag_v
);

    localparam int SHAMT_W = $clog2(DATA_W);
    localparam int MSB     = DATA_W - 1;

    ctrl_t             ctrl;
    logic [DATA_W-1:0] opnd2;
    logic [DATA_W-1:0] sh_res;
    logic              sh_c;
    logic [DATA_W-1:0] as_res;
    logic              as_c;
    logic              as_v;
    logic [DATA_W-1:0] nxt_val;
    flags_t            nxt_flags;
    flags_t            flags_q;

    sia_decode #(
        .DATA_W (DATA_W),
        .IMM_W  (IMM_W),
        .SMALL_W(SMALL_W)
    ) u_decode (
        .op_sel (op_sel),
        .opnd_b (opnd_b),
        .imm_fld(imm_fld),
        .ctrl   (ctrl),
        .opnd2  (opnd2)
    );

    sia_shifter #(
        .DATA_W (DATA_W),
        .SHAMT_W(SHAMT_W)
    ) u_shifter (
        .src (opnd_a),
        .amt (imm_fld[SHAMT_W-1:0]),
        .kind(ctrl.kind),
        .cin (carry_in),
        .res (sh_res),
        .cout(sh_c)
    );

    sia_addsub #(
        .DATA_W(DATA_W)
    ) u_addsub (
        .a   (opnd_a),
        .b   (opnd2),
        .sub (ctrl.is_sub),
        .sum (as_res),
        .cout(as_c),
        .ovf (as_v)
    );

    // Choose the computed value and the flags for this cycle.
    always_comb begin
        if (ctrl.use_shift) begin
            nxt_val     = sh_res;
            nxt_flags.c = sh_c;
            nxt_flags.v = 1'b0;
        end else if (ctrl.is_mov) begin
            nxt_val     = opnd2;
            nxt_flags.c = carry_in;
            nxt_flags.v = 1'b0;
        end else begin
            nxt_val     = as_res;
            nxt_flags.c = as_c;
            nxt_flags.v = as_v;
        end
        nxt_flags.n = nxt_val[MSB];
        nxt_flags.z = (nxt_val == '0);
    end

    // Output register: flags for every known code, result only on write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_out <= '0;
            res_wr  <= 1'b0;
            flags_q <= '0;
        end else begin
            res_wr <= ctrl.writes;
            if (ctrl.known) begin
                flags_q <= nxt_flags;
            end
            if (ctrl.writes) begin
                res_out <= nxt_val;
            end
        end
    end

    // Break the flag register out onto the individual pins.
    always_comb begin
        flag_n = flags_q.n;
        flag_z = flags_q.z;
        flag_c = flags_q.c;
        flag_v = flags_q.v;
    end

endmodule

// File: rtl/sia_unit_checker.sv
// Module: sia_unit_checker
// Timing properties on the ports of sia_unit, bound to every instance.
module sia_unit_checker
    import sia_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int IMM_W  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [3:0]        op_sel,
    input logic [DATA_W-1:0] opnd_a,
    input logic [IMM_W-1:0]  imm_fld,
    input logic              carry_in,
    input logic [DATA_W-1:0] res_out,
    input logic              res_wr,
    input logic              flag_n,
    input logic              flag_z,
    input logic              flag_c,
    input logic              flag_v
);

    localparam int SHAMT_W = $clog2(DATA_W);

    assert_cmp_no_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(op_sel) == 4'(OP_CMP_I8))
        |-> (!res_wr && $stable(res_out)));

    assert_flag_nz_R9: assert property (@(posedge clk) disable iff (!rst_n)
        res_wr |-> ((flag_z == (res_out == '0)) && (flag_n == res_out[DATA_W-1])));

    assert_lsl_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(op_sel) == 4'(OP_LSL_I5)
         && $past(imm_fld[SHAMT_W-1:0]) == '0)
        |-> (res_out == $past(opnd_a) && flag_c == $past(carry_in)));

    assert_no_overflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && ($past(op_sel) <= 4'(OP_ASR_I5)
                          || $past(op_sel) == 4'(OP_MOV_I8)))
        |-> !flag_v);

    assert_mov_value_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(op_sel) == 4'(OP_MOV_I8))
        |-> (res_wr && res_out == DATA_W'($past(imm_fld))));

    assert_unused_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(op_sel) > 4'(OP_SUB_I8))
        |-> (!res_wr && $stable(res_out)
             && $stable({flag_n, flag_z, flag_c, flag_v})));

endmodule

bind sia_unit sia_unit_checker #(
    .DATA_W(DATA_W),
    .IMM_W (IMM_W)
) u_sia_unit_checker (
    .clk     (clk),
    .rst_n   (rst_n),
    .op_sel  (op_sel),
    .opnd_a  (opnd_a),
    .imm_fld (imm_fld),
    .carry_in(carry_in),
    .res_out (res_out),
    .res_wr  (res_wr),
    .flag_n  (flag_n),
    .flag_z  (flag_z),
    .flag_c  (flag_c),
    .flag_v  (flag_v)
);

// File: tb/sia_unit_bench.sv
`timescale 1ns/1ps
// Directed bench for sia_unit: one task per scenario, each checking its
// own results against a model built from the requirements.
module sia_unit_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  op_sel = 4'd0;
    logic [31:0] opnd_a = '0;
    logic [31:0] opnd_b = '0;
    logic [7:0]  imm_fld = '0;
    logic        carry_in = 1'b0;
    logic [31:0] res_out;
    logic        res_wr;
    logic        flag_n, flag_z, flag_c, flag_v;

    int checks = 0;
    int errors = 0;

    logic [31:0] exp_res = '0;
    logic        exp_wr = 1'b0;
    logic [3:0]  exp_f = '0;

    always #2.5 clk = ~clk;

    sia_unit u_sia_unit (
        .clk(clk), .rst_n(rst_n), .op_sel(op_sel), .opnd_a(opnd_a),
        .opnd_b(opnd_b), .imm_fld(imm_fld), .carry_in(carry_in),
        .res_out(res_out), .res_wr(res_wr), .flag_n(flag_n),
        .flag_z(flag_z), .flag_c(flag_c), .flag_v(flag_v)
    );

    // Reference model: update the expected outputs for one issued code.
    task automatic model(input logic [3:0] op, input logic [31:0] a,
                         input logic [31:0] b, input logic [7:0] imm,
                         input logic cin);
        logic [63:0] t;
        logic [32:0] s;
        longint      sa;
        int          sh;
        logic [31:0] o;
        logic [31:0] val;
        logic        c, vv, wr, known;
        known = 1'b1; wr = 1'b1; c = cin; vv = 1'b0; val = '0;
        o = (op == 4'd3 || op == 4'd4) ? b :
            (op == 4'd5 || op == 4'd6) ? {29'd0, imm[2:0]} : {24'd0, imm};
        case (op)
            4'd0: begin
                sh = int'(imm[4:0]);
                t = {32'd0, a} << sh;
                val = t[31:0];
                c = (sh == 0) ? cin : t[32];
            end
            4'd1, 4'd2: begin
                sh = (imm[4:0] == 5'd0) ? 32 : int'(imm[4:0]);
                if (op == 4'd1) t = {a, 32'd0} >> sh;
                else t = $signed({a, 32'd0}) >>> sh;
                val = t[63:32];
                c = t[31];
            end
            4'd3, 4'd5, 4'd9: begin
                s = {1'b0, a} + {1'b0, o};
                val = s[31:0];
                c = s[32];
                sa = longint'($signed(a)) + longint'($signed(o));
                vv = (sa > 64'sd2147483647) || (sa < -64'sd2147483648);
            end
            4'd4, 4'd6, 4'd8, 4'd10: begin
                val = a - o;
                c = (a >= o);
                sa = longint'($signed(a)) - longint'($signed(o));
                vv = (sa > 64'sd2147483647) || (sa < -64'sd2147483648);
                wr = (op != 4'd8);
            end
            4'd7: val = o;
            default: known = 1'b0;
        endcase
        if (known) begin
            exp_f = {val[31], val == 32'd0, c, vv};
            exp_wr = wr;
            if (wr) exp_res = val;
        end else begin
            exp_wr = 1'b0;
        end
    endtask

    // Compare all outputs with the model state and count the check.
    task automatic compare(input string req);
        logic [36:0] act, exp;
        act = {res_out, res_wr, flag_n, flag_z, flag_c, flag_v};
        exp = {exp_res, exp_wr, exp_f};
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s op=%0d actual res=%h wr=%b nzcv=%b expected res=%h wr=%b nzcv=%b",
                     req, op_sel, act[36:5], act[4], act[3:0],
                     exp[36:5], exp[4], exp[3:0]);
        end
    endtask

    // Issue one operation at the falling edge and check one cycle later.
    task automatic issue(input logic [3:0] op, input logic [31:0] a,
                         input logic [31:0] b, input logic [7:0] imm,
                         input logic cin, input string req);
        op_sel = op; opnd_a = a; opnd_b = b; imm_fld = imm; carry_in = cin;
        model(op, a, b, imm, cin);
        @(posedge clk);
        @(negedge clk);
        compare(req);
    endtask

    // R1: outputs are cleared by reset.
    task automatic test_reset();
        rst_n = 1'b0;
        op_sel = 4'd7; imm_fld = 8'hFF; carry_in = 1'b1;
        exp_res = '0; exp_wr = 1'b0; exp_f = '0;
        @(posedge clk);
        @(negedge clk);
        compare("R1 reset");
        rst_n = 1'b1;
    endtask

    // R3: left shift at amounts 0, 1, 31 and mid range.
    task automatic test_lsl();
        issue(4'd0, 32'h8000_0001, '0, 8'd0, 1'b1, "R3 lsl0 cin1");
        issue(4'd0, 32'h8000_0001, '0, 8'd0, 1'b0, "R3 lsl0 cin0");
        issue(4'd0, 32'h8000_0001, '0, 8'd1, 1'b0, "R3 lsl1");
        issue(4'd0, 32'h0000_0003, '0, 8'd31, 1'b0, "R3 lsl31");
        issue(4'd0, 32'h1234_5678, '0, 8'd4, 1'b1, "R3 lsl4");
    endtask

    // R4: right shifts with zero meaning 32, plus 1 and 31.
    task automatic test_right();
        issue(4'd1, 32'h8000_0001, '0, 8'd0, 1'b0, "R4 lsr0");
        issue(4'd1, 32'h8000_0001, '0, 8'd1, 1'b0, "R4 lsr1");
        issue(4'd1, 32'hC000_0000, '0, 8'd31, 1'b0, "R4 lsr31");
        issue(4'd2, 32'h8000_0000, '0, 8'd0, 1'b0, "R4 asr0 neg");
        issue(4'd2, 32'h7FFF_FFFF, '0, 8'd0, 1'b1, "R4 asr0 pos");
        issue(4'd2, 32'h8000_0003, '0, 8'd1, 1'b0, "R4 asr1");
        issue(4'd2, 32'hC000_0000, '0, 8'd31, 1'b0, "R4 asr31");
    endtask

    // R5: bits above each constant width are ignored.
    task automatic test_fields();
        issue(4'd0, 32'h0000_00F0, '0, 8'hE3, 1'b0, "R5 shift uses 5 bits");
        issue(4'd5, 32'd10, '0, 8'hFD, 1'b0, "R5 add3 uses 3 bits");
        issue(4'd6, 32'd10, '0, 8'hFA, 1'b0, "R5 sub3 uses 3 bits");
        issue(4'd9, 32'd1, '0, 8'hFF, 1'b0, "R5 add8 full field");
    endtask

    // R6 and R7: carry, borrow and overflow corners.
    task automatic test_arith();
        issue(4'd3, 32'h7FFF_FFFF, 32'd1, 8'd0, 1'b0, "R6 add pos ovf");
        issue(4'd3, 32'hFFFF_FFFF, 32'd1, 8'd0, 1'b0, "R6 add carry zero");
        issue(4'd3, 32'h8000_0000, 32'h8000_0000, 8'd0, 1'b0, "R6 add neg ovf");
        issue(4'd9, 32'hFFFF_FF01, '0, 8'd255, 1'b0, "R6 add8 wrap");
        issue(4'd4, 32'd5, 32'd5, 8'd0, 1'b0, "R7 sub equal");
        issue(4'd4, 32'd3, 32'd5, 8'd0, 1'b1, "R7 sub borrow");
        issue(4'd4, 32'h8000_0000, 32'd1, 8'd0, 1'b0, "R7 sub ovf");
        issue(4'd10, 32'd100, '0, 8'd145, 1'b0, "R7 sub8 borrow");
        issue(4'd6, 32'd7, '0, 8'd7, 1'b0, "R7 sub3 zero");
    endtask

    // R8 and R9: compare refreshes flags while the result holds.
    task automatic test_compare();
        issue(4'd7, 32'd0, '0, 8'd62, 1'b0, "R10 mov before cmp");
        issue(4'd8, 32'd62, '0, 8'd62, 1'b0, "R8 cmp equal R9 zero");
        issue(4'd8, 32'd1, '0, 8'd200, 1'b0, "R8 cmp less R9 neg");
        issue(4'd3, 32'h0000_1000, 32'h0000_0001, 8'd0, 1'b0, "R9 write then cmp");
        issue(4'd8, 32'h8000_0000, '0, 8'd1, 1'b1, "R8 cmp ovf");
    endtask

    // R10: move writes the constant, keeps carry, clears overflow.
    task automatic test_move();
        issue(4'd3, 32'h7FFF_FFFF, 32'd1, 8'd0, 1'b0, "R10 set V first");
        issue(4'd7, 32'hDEAD_BEEF, '0, 8'd128, 1'b1, "R10 mov cin1");
        issue(4'd7, 32'hDEAD_BEEF, '0, 8'd0, 1'b0, "R10 mov zero");
        issue(4'd7, 32'd0, '0, 8'd255, 1'b1, "R10 mov 255");
    endtask

    // R11: unused codes hold result and flags and drop the strobe.
    task automatic test_unused();
        issue(4'd4, 32'd3, 32'd5, 8'd0, 1'b0, "R11 prime");
        for (int k = 11; k < 16; k++) begin
            issue(4'(k), 32'hFFFF_FFFF, 32'hFFFF_FFFF, 8'hFF, 1'b1,
                  "R11 unused hold");
        end
    endtask

    // R2: random mixed traffic back to back, one-cycle latency throughout.
    task automatic test_random();
        for (int k = 0; k < 300; k++) begin
            issue(4'($urandom_range(0, 15)), $urandom, $urandom,
                  8'($urandom), 1'($urandom), "R2 random");
        end
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        #100000;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        @(negedge clk);
        test_reset();
        test_lsl();
        test_right();
        test_fields();
        test_arith();
        test_compare();
        test_move();
        test_unused();
        test_random();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule